// File: doc/BRIEF.md
# Latched Gray-Code Event Counter

This block counts events on a single detector channel. A raw pulse line of arbitrary width is brought into the clock domain, reduced to one qualified event per rising edge, and screened by a hold-off window so that edges arriving too soon after an accepted one are dropped. Each qualified event advances a counter kept in reflected Gray code, so only one register bit toggles per event.

A latch strobe copies the running count into a holding register. Counting carries on without a pause, so the held value from one acquisition window can be shifted out while the next window is already being counted. A test-mode select replaces the pulse line with the serial transmitter's clock, which yields a known number of events. A synchronous clear starts a new window. The counter wraps to zero after its largest code and then raises a sticky overflow flag. The held value is also given in plain binary for checking.

Top module: `gray_event_counter`

## Requirements
- R1: The count advances by one binary step per qualified event, and its stored form is Gray code (gray = bin ^ (bin >> 1)), so exactly one counter bit changes per event. `held_bin` is the binary decode of `held_gray`: bit i is the XOR of held_gray bits i through CNT_W-1.
- R2: An event is counted only if `cnt_en` is high in the cycle the event is qualified. While `cnt_en` is low the count does not change.
- R3: A one-cycle high on `latch_stb` copies the whole count into `held_gray` at that clock edge. Without a strobe `held_gray` keeps its value while counting continues.
- R4: Each rising edge of the selected input counts once, however many cycles the input stays high.
- R5: After an accepted edge, any edge detected within the next GUARD_CYC clock cycles is ignored. An edge detected GUARD_CYC+1 or more cycles later is counted.
- R6: With `test_mode` high, `test_clk` is the event source and `pulse_in` has no effect. With `test_mode` low, `pulse_in` is the source.
- R7: A one-cycle high on `sync_clr` clears the count and the overflow flag at the next edge. It does not change `held_gray`.
- R8: An event counted at the largest Gray code wraps the count to zero and sets `ovf_flag`. The flag stays set until `sync_clr` or reset.
- R9: A low on `rst_n` clears the count, `held_gray` and `ovf_flag` at once. Reset release takes effect through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Raw event line, any width |
| test_clk | input | 1 | Transmitter clock, used as the event source in test mode |
| test_mode | input | 1 | 1 selects test_clk as the source, 0 selects pulse_in |
| cnt_en | input | 1 | Count enable |
| latch_stb | input | 1 | Copies the count into the holding register |
| sync_clr | input | 1 | Synchronous clear of the count and overflow flag |
| held_gray | output | CNT_W | Held count in Gray code |
| held_bin | output | CNT_W | Held count decoded to binary |
| ovf_flag | output | 1 | Sticky wrap indicator |

## Verification
The bench builds the counter with CNT_W = 6 and GUARD_CYC = 2. The narrow counter puts the wrap from the top code back to zero, and the sticky flag, within 64 events. A two-cycle hold-off lets pulse trains with periods of two and three cycles separate ignored edges from accepted ones. Wide pulses, enable gating, the test-clock source, the clear during a held readout, and an asynchronous reset in mid-run are each read back through the latch path.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;
  typedef enum logic {
    SRC_PULSE = 1'b0,
    SRC_TEST  = 1'b1
  } src_sel_e;
endpackage

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
  parameter int W = 32
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  assign bin_o[W-1] = gray_i[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_fold
    assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
  end
endmodule

// File: rtl/pulse_qualifier.sv
module pulse_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_CYC   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic raw_in,
  input  logic enable,
  output logic count_stb
);
  localparam int GW = $clog2(GUARD_CYC + 2);
  localparam logic [GW-1:0] GUARD_LOAD = GW'(GUARD_CYC);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic [GW-1:0]          guard_q, guard_d;
  logic                   edge_seen, accept;

  always_comb begin
    sync_d    = {sync_q[SYNC_STAGES-2:0], raw_in};
    prev_d    = sync_q[SYNC_STAGES-1];
    edge_seen = sync_q[SYNC_STAGES-1] & ~prev_q;
    accept    = edge_seen & enable & (guard_q == '0);
    if (clr) begin
      guard_d = '0;
    end else if (accept) begin
      guard_d = GUARD_LOAD;
    end else if (guard_q != '0) begin
      guard_d = guard_q - 1'b1;
    end else begin
      guard_d = guard_q;
    end
  end

  assign count_stb = accept & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      guard_q <= '0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= prev_d;
      guard_q <= guard_d;
    end
  end
endmodule

// File: rtl/gray_step_counter.sv
module gray_step_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_gray,
  output logic             ovf
);
  logic [CNT_W-1:0] cur_bin, nxt_bin, gray_q, gray_d;
  logic             ovf_q, ovf_d;

  gray_to_bin #(.W(CNT_W)) u_dec (
    .gray_i (gray_q),
    .bin_o  (cur_bin)
  );

  always_comb begin
    nxt_bin = cur_bin + 1'b1;
    gray_d  = gray_q;
    ovf_d   = ovf_q;
    if (clr) begin
      gray_d = '0;
      ovf_d  = 1'b0;
    end else if (step) begin
      gray_d = nxt_bin ^ (nxt_bin >> 1);
      if (&cur_bin) begin
        ovf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gray_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      gray_q <= gray_d;
      ovf_q  <= ovf_d;
    end
  end

  assign cnt_gray = gray_q;
  assign ovf      = ovf_q;
endmodule

// File: rtl/gray_event_counter.sv
module gray_event_counter
  import gray_cnt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int GUARD_CYC   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             test_clk,
  input  logic             test_mode,
  input  logic             cnt_en,
  input  logic             latch_stb,
  input  logic             sync_clr,
  output logic [CNT_W-1:0] held_gray,
  output logic [CNT_W-1:0] held_bin,
  output logic             ovf_flag
);
  logic [1:0]       rst_pipe;
  logic             core_rst_n;
  src_sel_e         src_sel;
  logic             src_line;
  logic             step;
  logic [CNT_W-1:0] cnt_gray;
  logic [CNT_W-1:0] held_q, held_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  assign src_sel  = test_mode ? SRC_TEST : SRC_PULSE;
  assign src_line = (src_sel == SRC_TEST) ? test_clk : pulse_in;

  pulse_qualifier #(
    .SYNC_STAGES (SYNC_STAGES),
    .GUARD_CYC   (GUARD_CYC)
  ) u_qual (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .clr       (sync_clr),
    .raw_in    (src_line),
    .enable    (cnt_en),
    .count_stb (step)
  );

  gray_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .clr      (sync_clr),
    .step     (step),
    .cnt_gray (cnt_gray),
    .ovf      (ovf_flag)
  );

  always_comb begin
    held_d = held_q;
    if (latch_stb) held_d = cnt_gray;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) held_q <= '0;
    else             held_q <= held_d;
  end

  assign held_gray = held_q;

  gray_to_bin #(.W(CNT_W)) u_held_dec (
    .gray_i (held_q),
    .bin_o  (held_bin)
  );
endmodule

// File: rtl/gray_event_counter_chk.sv
module gray_event_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             latch_stb,
  input logic             sync_clr,
  input logic [CNT_W-1:0] cnt_gray,
  input logic [CNT_W-1:0] held_gray,
  input logic [CNT_W-1:0] held_bin,
  input logic             ovf_flag
);
  p_one_bit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_clr |=> ($countones(cnt_gray ^ $past(cnt_gray)) <= 1));

  p_bin_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((held_bin ^ (held_bin >> 1)) == held_gray));

  p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !sync_clr) |=> $stable(cnt_gray));

  p_latch_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> (held_gray == $past(cnt_gray)));

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(held_gray));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (cnt_gray == '0 && !ovf_flag));

  p_sticky_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !sync_clr) |=> ovf_flag);
endmodule

bind gray_event_counter gray_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .latch_stb (latch_stb),
  .sync_clr  (sync_clr),
  .cnt_gray  (cnt_gray),
  .held_gray (held_gray),
  .held_bin  (held_bin),
  .ovf_flag  (ovf_flag)
);

// File: tb/gray_event_counter_test.sv
`timescale 1ns/1ps
module gray_event_counter_test;
  localparam int W     = 6;
  localparam int G     = 2;
  localparam int MODV  = 1 << W;
  localparam int NVEC  = 6;
  localparam int HI[NVEC]   = '{1, 1, 5, 20, 1, 2};
  localparam int LO[NVEC]   = '{1, 2, 1, 3, 3, 1};
  localparam int REPS[NVEC] = '{5, 4, 3, 2, 3, 4};

  logic clk = 1'b0;
  logic rst_n, pulse_in, test_clk, test_mode, cnt_en, latch_stb, sync_clr;
  logic [W-1:0] held_gray, held_bin;
  logic ovf_flag;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  int saved;
  bit done = 0;

  always #2.5 clk = ~clk;

  gray_event_counter #(.CNT_W(W), .GUARD_CYC(G)) uut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .test_clk(test_clk),
    .test_mode(test_mode), .cnt_en(cnt_en), .latch_stb(latch_stb),
    .sync_clr(sync_clr), .held_gray(held_gray), .held_bin(held_bin),
    .ovf_flag(ovf_flag)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int counted(int hi, int lo, int reps);
    int k = (G + 1 + hi + lo - 1) / (hi + lo);
    return (reps + k - 1) / k;
  endfunction

  task automatic pulses(int hi, int lo, int reps);
    for (int i = 0; i < reps; i++) begin
      pulse_in = 1'b1; tick(hi);
      pulse_in = 1'b0; tick(lo);
    end
    tick(8);
  endtask

  task automatic do_latch();
    latch_stb = 1'b1; tick(1);
    latch_stb = 1'b0; tick(1);
  endtask

  task automatic check_held(string req, int val);
    int b = val % MODV;
    int g = b ^ (b >> 1);
    chk(int'(held_bin) == b, req, int'(held_bin), b);
    chk(int'(held_gray) == g, req, int'(held_gray), g);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pulse_in = 1'b0; test_clk = 1'b0; test_mode = 1'b0;
    cnt_en = 1'b0; latch_stb = 1'b0; sync_clr = 1'b0;
    tick(3);
    // R9: reset state
    chk(held_gray == '0, "R9 held at reset", int'(held_gray), 0);
    chk(ovf_flag == 1'b0, "R9 ovf at reset", int'(ovf_flag), 0);
    rst_n = 1'b1; tick(4);
    sync_clr = 1'b1; tick(1); sync_clr = 1'b0;
    cnt_en = 1'b1; tick(2);

    // R1 R4 R5 vector walk
    for (int v = 0; v < NVEC; v++) begin
      pulses(HI[v], LO[v], REPS[v]);
      exp_cnt += counted(HI[v], LO[v], REPS[v]);
      do_latch();
      check_held("R1/R4/R5 vector", exp_cnt);
    end

    // R3: held stays while counting continues
    saved = exp_cnt;
    pulses(1, 3, 3); exp_cnt += 3;
    check_held("R3 hold without strobe", saved);
    do_latch();
    check_held("R3 copy on strobe", exp_cnt);

    // R2: enable low
    cnt_en = 1'b0;
    pulses(1, 3, 4);
    cnt_en = 1'b1;
    do_latch();
    check_held("R2 disabled count", exp_cnt);

    // R6: test mode ignores pulse_in, counts test_clk
    test_mode = 1'b1; tick(4);
    pulses(1, 3, 3);
    do_latch();
    check_held("R6 pulse_in ignored", exp_cnt);
    for (int i = 0; i < 5; i++) begin
      test_clk = 1'b1; tick(2);
      test_clk = 1'b0; tick(2);
    end
    tick(8);
    exp_cnt += 5;
    do_latch();
    check_held("R6 test clock source", exp_cnt);
    test_mode = 1'b0; tick(4);

    // R7: clear keeps held, zeroes count
    saved = exp_cnt;
    sync_clr = 1'b1; tick(1); sync_clr = 1'b0; tick(2);
    check_held("R7 held kept", saved);
    do_latch();
    exp_cnt = 0;
    check_held("R7 count cleared", 0);

    // R8: wrap and sticky overflow
    pulses(1, 3, MODV - 1);
    do_latch();
    check_held("R8 top code", MODV - 1);
    chk(ovf_flag == 1'b0, "R8 no ovf before wrap", int'(ovf_flag), 0);
    pulses(1, 3, 1);
    do_latch();
    check_held("R8 wrap to zero", 0);
    chk(ovf_flag == 1'b1, "R8 ovf set", int'(ovf_flag), 1);
    pulses(1, 3, 1);
    do_latch();
    check_held("R8 count after wrap", 1);
    chk(ovf_flag == 1'b1, "R8 ovf sticky", int'(ovf_flag), 1);
    sync_clr = 1'b1; tick(1); sync_clr = 1'b0; tick(1);
    chk(ovf_flag == 1'b0, "R7 ovf cleared", int'(ovf_flag), 0);

    // R9: asynchronous reset mid-run
    pulses(1, 3, 4);
    do_latch();
    check_held("R9 pre-reset count", 4);
    #1.0 rst_n = 1'b0; #1.0;
    chk(held_gray == '0, "R9 async held clear", int'(held_gray), 0);
    tick(2); rst_n = 1'b1; tick(4);
    do_latch();
    check_held("R9 count cleared by reset", 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule